// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a single-port static memory. It has a 32-bit common data path split into four byte lanes. An access starts when one of two address strobes is seen: a processor-side strobe or a controller-side strobe. The low two address bits seed a burst counter. An advance input then steps that counter through up to four beats, in either linear or interleaved order. Read data passes through an output register. Write data and lane enables arrive one cycle after the address.

The data bus is modelled at pad level, with separate input and output words and a drive-enable flag (`dqOe`). The drive-enable flag stands in for the tri-state control of the bidirectional bus. Three conditions force the bus off: a write request, a deasserted output enable, or the sleep input. While the sleep input is high, no accesses are accepted. After sleep ends, a short recovery window also rejects new accesses. The array keeps its contents through sleep.

Top module: `burst_sram`

## Requirements
- R1: Read data for an address registered at clock edge N is on `dqOut` after edge N+1. `dqOe` is high only while `oeN` is low. Raising `oeN` releases the bus in the same cycle.
- R2: On a start, the burst counter loads from `addr[1:0]`. With `modeInterleave` low, the beats follow start+k mod 4 (for example 2,3,0,1). The upper address bits stay fixed.
- R3: With `modeInterleave` high, the beat offsets are start XOR k (for example 1,0,3,2 and 3,2,1,0).
- R4: While a burst is active and `advN` is high, the counter holds. The same word is accessed again each cycle until `advN` goes low.
- R5: `adspN` low starts an access only when `ce1N` is low. It is ignored when `ce1N` is high, and masked while a burst is active and `advN` is low. `adscN` low always starts or deselects.
- R6: A strobe while `ce1N`, `ce2` or `ce3N` is inactive (enables: `ce1N`=0, `ce2`=1, `ce3N`=0) deselects the block: the burst ends and the bus is not driven.
- R7: With `bweN` low, lane i (bits 8i+7:8i) is written when `bwN[i]` is 0, and the other lanes keep their contents. With `bweN` high, `bwN` has no effect. `gwN` low writes all four lanes.
- R8: Write data and lane enables are taken at the edge after the address edge, and committed there. A read that follows returns the new value.
- R9: Whenever `gwN` is low, or `bweN` is low with any `bwN` bit low, `dqOe` is low in that same cycle, regardless of `oeN`.
- R10: While `zz` is high, strobes are ignored and `dqOe` is low. Array contents are kept.
- R11: After `zz` falls, strobes at the next two clock edges are ignored. A strobe at the third edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| adspN | input | 1 | Processor-side address strobe, active low |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write of all lanes, active low |
| bweN | input | 1 | Byte-write qualifier, active low |
| bwN | input | LANES | Per-lane write selects, active low |
| oeN | input | 1 | Output enable, active low |
| zz | input | 1 | Sleep request, active high |
| modeInterleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| dqIn | input | LANES*LANE_W | Write data from the bus |
| dqOut | output | LANES*LANE_W | Registered read data |
| dqOe | output | 1 | Bus drive enable |

## Verification
Two events can land in the same cycle: a registered read word waiting on the bus with `oeN` low, and a write request for the next beat. The bench first lets a read word appear. Within that same cycle it then asserts `gwN`, with the same word on `dqIn`. It expects the drive flag to drop at once, and the array to keep the same word. A second clash is an `adspN` strobe arriving while the burst is advancing. That strobe is judged by the word delivered on the following beats.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  localparam int BURST_W = 2;

  typedef struct packed {
    logic readBeat;
    logic writeBeat;
    logic forceHiZ;
  } bsram_strobe_t;

  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_START,
    STEP_ADVANCE,
    STEP_HOLD
  } beat_step_e;

  function automatic logic [BURST_W-1:0] burstLow(
    input logic [BURST_W-1:0] startOff,
    input logic [BURST_W-1:0] beatCnt,
    input logic               interleave
  );
    if (interleave) return startOff ^ beatCnt;
    return startOff + beatCnt;
  endfunction

endpackage

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 4,
  parameter int RECOVER_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              zz,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [LANES-1:0]  laneWe,
  output bsram_strobe_t     strobes
);

  localparam int HI_W   = ADDR_W - BURST_W;
  localparam int RCNT_W = $clog2(RECOVER_CYC + 1);

  logic [HI_W-1:0]    baseHiQ;
  logic [BURST_W-1:0] startOffQ;
  logic [BURST_W-1:0] beatCntQ;
  logic               beatValidQ;
  logic               burstActiveQ;
  logic [RCNT_W-1:0]  recovCntQ;

  logic       chipSel;
  logic       sleepBlock;
  logic       adspSeen;
  logic       startReq;
  logic       writeReq;
  beat_step_e step;

  assign chipSel    = !ce1N && ce2 && !ce3N;
  assign sleepBlock = zz || (recovCntQ != '0);
  assign adspSeen   = !adspN && !ce1N && !(burstActiveQ && !advN);
  assign startReq   = adspSeen || !adscN;
  assign writeReq   = !gwN || (!bweN && (bwN != '1));

  always_comb begin
    if (sleepBlock)        step = STEP_IDLE;
    else if (startReq)     step = chipSel ? STEP_START : STEP_IDLE;
    else if (burstActiveQ) step = advN ? STEP_HOLD : STEP_ADVANCE;
    else                   step = STEP_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHiQ      <= '0;
      startOffQ    <= '0;
      beatCntQ     <= '0;
      beatValidQ   <= 1'b0;
      burstActiveQ <= 1'b0;
    end else begin
      unique case (step)
        STEP_START: begin
          baseHiQ      <= addr[ADDR_W-1:BURST_W];
          startOffQ    <= addr[BURST_W-1:0];
          beatCntQ     <= '0;
          beatValidQ   <= 1'b1;
          burstActiveQ <= 1'b1;
        end
        STEP_ADVANCE: begin
          beatCntQ   <= beatCntQ + 1'b1;
          beatValidQ <= 1'b1;
        end
        STEP_HOLD: begin
          beatValidQ <= 1'b1;
        end
        default: begin
          beatValidQ   <= 1'b0;
          burstActiveQ <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 recovCntQ <= '0;
    else if (zz)               recovCntQ <= RCNT_W'(RECOVER_CYC);
    else if (recovCntQ != '0)  recovCntQ <= recovCntQ - 1'b1;
  end

  assign beatAddr = {baseHiQ, burstLow(startOffQ, beatCntQ, modeInterleave)};

  always_comb begin
    if (!gwN)       laneWe = '1;
    else if (!bweN) laneWe = ~bwN;
    else            laneWe = '0;
  end

  always_comb begin
    strobes.writeBeat = beatValidQ && writeReq && !zz;
    strobes.readBeat  = beatValidQ && !writeReq && !zz;
    strobes.forceHiZ  = writeReq || zz;
  end

endmodule

// File: rtl/bsram_datapath.sv
`timescale 1ns/1ps
module bsram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       beatAddr,
  input  logic [LANES-1:0]        laneWe,
  input  bsram_strobe_t           strobes,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] outQ;
  logic              rdValidQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.writeBeat && laneWe[l])
        laneMem[beatAddr] <= dqIn[l*LANE_W +: LANE_W];
    end

    assign readWord[l*LANE_W +: LANE_W] = laneMem[beatAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      outQ     <= '0;
    end else begin
      rdValidQ <= strobes.readBeat;
      if (strobes.readBeat) outQ <= readWord;
    end
  end

  assign dqOut = outQ;
  assign dqOe  = rdValidQ && !oeN && !strobes.forceHiZ;

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int RECOVER_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    oeN,
  input  logic                    zz,
  input  logic                    modeInterleave,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);

  logic [ADDR_W-1:0] beatAddr;
  logic [LANES-1:0]  laneWe;
  bsram_strobe_t     ctrlStrobes;

  bsram_ctrl #(
    .ADDR_W     (ADDR_W),
    .LANES      (LANES),
    .RECOVER_CYC(RECOVER_CYC)
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .addr          (addr),
    .adspN         (adspN),
    .adscN         (adscN),
    .advN          (advN),
    .ce1N          (ce1N),
    .ce2           (ce2),
    .ce3N          (ce3N),
    .gwN           (gwN),
    .bweN          (bweN),
    .bwN           (bwN),
    .zz            (zz),
    .modeInterleave(modeInterleave),
    .beatAddr      (beatAddr),
    .laneWe        (laneWe),
    .strobes       (ctrlStrobes)
  );

  bsram_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .beatAddr(beatAddr),
    .laneWe  (laneWe),
    .strobes (ctrlStrobes),
    .oeN     (oeN),
    .dqIn    (dqIn),
    .dqOut   (dqOut),
    .dqOe    (dqOe)
  );

endmodule

// File: rtl/bsram_checker.sv
`timescale 1ns/1ps
module bsram_checker (
  input logic clk,
  input logic rstN,
  input logic zz,
  input logic adscN,
  input logic ce1N,
  input logic oeN,
  input logic gwN,
  input logic dqOe,
  input logic writeBeat
);

  p_oe_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe);

  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!adscN && ce1N && !zz) |=> ##1 !dqOe);

  p_late_write_no_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    writeBeat |=> !dqOe);

  p_write_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    !gwN |-> !dqOe);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    zz |=> !dqOe);

  p_recover_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zz) |=> ##1 !dqOe);

endmodule

bind burst_sram bsram_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .zz       (zz),
  .adscN    (adscN),
  .ce1N     (ce1N),
  .oeN      (oeN),
  .gwN      (gwN),
  .dqOe     (dqOe),
  .writeBeat(ctrlStrobes.writeBeat)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic          ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic          gwN = 1'b1, bweN = 1'b1;
  logic [3:0]    bwN = 4'hF;
  logic          oeN = 1'b0, zz = 1'b0, modeInterleave = 1'b0;
  logic [31:0]   dqIn = '0;
  logic [31:0]   dqOut;
  logic          dqOe;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string curTag = "R1 reset";

  always #2 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .zz(zz),
    .modeInterleave(modeInterleave), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  // ---------------- reference model ----------------
  logic [31:0] refMem [DEPTH];
  logic [AW-1:0] mBase;
  logic [1:0]  mOff, mCnt;
  bit          mBeat, mBurst, mRd;
  int          mRecov;
  logic [31:0] mRdData;

  function automatic logic [AW-1:0] modelAddr();
    logic [1:0] low;
    low = modeInterleave ? (mOff ^ mCnt) : (mOff + mCnt);
    return {mBase[AW-1:2], low};
  endfunction

  function automatic logic [31:0] pat(input int a);
    return {8'(a + 64), 8'(a ^ 195), 8'(a * 3), 8'(255 - a)};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBeat = 0; mBurst = 0; mRd = 0; mRecov = 0; mCnt = 0; mOff = 0; mBase = 0;
      mRdData = '0;
    end else begin
      bit wr, sel, adspOk;
      logic [AW-1:0] a;
      wr = !gwN || (!bweN && bwN != 4'hF);
      a  = modelAddr();
      if (!zz && mBeat) begin
        if (wr) begin
          for (int l = 0; l < 4; l++)
            if (!gwN || !bwN[l]) refMem[a][l*8 +: 8] = dqIn[l*8 +: 8];
        end else begin
          mRdData = refMem[a];
        end
        mRd = !wr;
      end else begin
        mRd = 0;
      end
      sel = !ce1N && ce2 && !ce3N;
      if (zz) begin
        mBeat = 0; mBurst = 0; mRecov = 2;
      end else if (mRecov > 0) begin
        mRecov = mRecov - 1; mBeat = 0; mBurst = 0;
      end else begin
        adspOk = !adspN && !ce1N && !(mBurst && !advN);
        if (adspOk || !adscN) begin
          if (sel) begin
            mBase = addr; mOff = addr[1:0]; mCnt = 0; mBeat = 1; mBurst = 1;
          end else begin
            mBeat = 0; mBurst = 0;
          end
        end else if (mBurst) begin
          if (!advN) mCnt = mCnt + 1;
          mBeat = 1;
        end else begin
          mBeat = 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expOe;
      expOe = mRd && !oeN && gwN && !(!bweN && bwN != 4'hF) && !zz;
      check(dqOe == expOe, {curTag, " per-cycle drive"}, 32'(dqOe), 32'(expOe));
      if (expOe) check(dqOut == mRdData, {curTag, " per-cycle data"}, dqOut, mRdData);
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      finishRun();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    adspN = 1; adscN = 1; advN = 1; ce1N = 0; ce2 = 1; ce3N = 0;
    gwN = 1; bweN = 1; bwN = 4'hF; zz = 0; dqIn = '0;
  endtask

  task automatic expectData(input string tag, input logic [31:0] exp);
    @(negedge clk);
    check(dqOe === 1'b1, {tag, " drive"}, 32'(dqOe), 32'h1);
    check(dqOut == exp, {tag, " data"}, dqOut, exp);
  endtask

  task automatic expectQuiet(input string tag);
    @(negedge clk);
    check(dqOe === 1'b0, {tag, " bus released"}, 32'(dqOe), 32'h0);
  endtask

  task automatic writeWord(input int a, input logic [31:0] d);
    quiet(); oeN = 1; adscN = 0; addr = AW'(a); tick();
    quiet(); gwN = 0; dqIn = d; tick();
    quiet();
  endtask

  task automatic readCheck(input int a, input logic [31:0] exp, input string tag);
    quiet(); oeN = 0; adscN = 0; addr = AW'(a); tick();
    quiet(); tick();
    expectData(tag, exp);
  endtask

  task automatic burstCheck(input int base, input int off, input bit mode, input string tag);
    quiet(); oeN = 0; modeInterleave = mode; adscN = 0; addr = AW'(base * 4 + off); tick();
    quiet(); advN = 0; tick();
    for (int k = 0; k < 4; k++) begin
      int low;
      low = mode ? (off ^ k) : ((off + k) % 4);
      expectData(tag, pat(base * 4 + low));
      advN = (k < 2) ? 1'b0 : 1'b1;
      if (k < 3) tick();
    end
  endtask

  // ---------------- test sequence ----------------
  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    quiet(); oeN = 0;
    repeat (3) tick();
    check(dqOe === 1'b0, "R1 reset drive", 32'(dqOe), 32'h0);
    rstN = 1;
    tick();
    expectQuiet("R1 after reset");

    curTag = "R8 fill";
    for (int i = 0; i < DEPTH; i++) writeWord(i, pat(i));

    curTag = "R1 single read";
    readCheck(5, pat(5), "R1 single read");
    readCheck(63, pat(63), "R8 read after late write");

    curTag = "R2 linear";
    burstCheck(2, 2, 1'b0, "R2 linear from offset 2");
    curTag = "R3 interleaved";
    burstCheck(3, 1, 1'b1, "R3 interleaved from offset 1");
    burstCheck(1, 3, 1'b1, "R3 interleaved from offset 3");
    modeInterleave = 0;

    curTag = "R4 suspend";
    quiet(); oeN = 0; adscN = 0; addr = AW'(16); tick();
    quiet(); advN = 0; tick();
    expectData("R4 beat0", pat(16)); advN = 1; tick();
    expectData("R4 beat1", pat(17)); advN = 1; tick();
    expectData("R4 held repeat", pat(17)); advN = 0; tick();
    expectData("R4 held then resume", pat(17)); advN = 0; tick();
    expectData("R4 resumed beat2", pat(18));

    curTag = "R5 strobe gating";
    quiet(); oeN = 0; adscN = 0; addr = AW'(24); tick();
    quiet(); advN = 0; tick();
    expectData("R5 beat0", pat(24));
    adspN = 0; addr = AW'(50); advN = 0; tick();
    expectData("R5 adsp masked while advancing", pat(25));
    quiet(); oeN = 0; adspN = 0; ce1N = 1; addr = AW'(50); advN = 1; tick();
    expectData("R5 beat2", pat(26));
    quiet(); oeN = 0; tick();
    expectData("R5 adsp ignored with ce1N high", pat(26));
    quiet(); oeN = 0; adspN = 0; addr = AW'(40); tick();
    quiet(); tick();
    expectData("R5 adsp start read", pat(40));

    curTag = "R6 deselect";
    quiet(); oeN = 0; adscN = 0; ce2 = 0; addr = AW'(3); tick();
    quiet(); tick();
    expectQuiet("R6 ce2 low deselect");
    quiet(); oeN = 0; adscN = 0; ce3N = 1; addr = AW'(3); tick();
    quiet(); tick();
    expectQuiet("R6 ce3N high deselect");

    curTag = "R7 byte write";
    quiet(); oeN = 1; adscN = 0; addr = AW'(20); tick();
    quiet(); bweN = 0; bwN = 4'b1010; dqIn = 32'h11223344; tick();
    readCheck(20, (pat(20) & 32'hFF00FF00) | 32'h00220044, "R7 lanes 0 and 2 only");
    quiet(); oeN = 1; adscN = 0; addr = AW'(20); tick();
    quiet(); bweN = 1; bwN = 4'b0000; dqIn = 32'h0; tick();
    readCheck(20, (pat(20) & 32'hFF00FF00) | 32'h00220044, "R7 bwN without bweN ignored");
    quiet(); oeN = 1; adscN = 0; addr = AW'(21); tick();
    quiet(); gwN = 0; bwN = 4'hF; dqIn = 32'hCAFEF00D; tick();
    readCheck(21, 32'hCAFEF00D, "R7 global write all lanes");

    curTag = "R9 forced release";
    readCheck(30, pat(30), "R9 read before write");
    gwN = 0; dqIn = pat(30);
    #0.5;
    check(dqOe === 1'b0, "R9 write request releases bus", 32'(dqOe), 32'h0);
    tick();
    quiet();
    readCheck(30, pat(30), "R9 word after same-cycle write");
    oeN = 1;
    #0.5;
    check(dqOe === 1'b0, "R1 oeN high releases bus", 32'(dqOe), 32'h0);

    curTag = "R10 sleep";
    quiet(); oeN = 0; adscN = 0; ce1N = 1; tick();
    quiet(); oeN = 0; zz = 1; adscN = 0; addr = AW'(7); tick();
    for (int i = 0; i < 3; i++) begin
      expectQuiet("R10 sleeping");
      tick();
    end
    curTag = "R11 recovery";
    quiet(); oeN = 0; adscN = 0; addr = AW'(9); tick();
    expectQuiet("R11 first recovery edge");
    tick();
    expectQuiet("R11 second recovery edge");
    adscN = 0; addr = AW'(12); tick();
    quiet();
    expectQuiet("R11 ignored strobes gave no data");
    tick();
    expectData("R10 contents kept, R11 third edge accepted", pat(12));

    quiet(); oeN = 1; tick(); tick();
    finishRun();
  end

endmodule